// File: doc/BRIEF.md
# Card slot interrupt and status registers

This block is a small word-addressed register file that sits beside a removable memory card slot. It watches two level inputs from the slot: the card-insertion detector and the write-protect switch. A card arriving is caught in a sticky status bit. That bit drives the block's interrupt output until software acknowledges it with a write-one-to-clear. The write-protect switch is not caught in a bit. It is reported live in the same status word.

Four word locations are decoded. Location 0 returns a constant identification value chosen by parameter. Location 2 is the interrupt and status word. Locations 1 and 3 are placeholders: reads return zero and writes are accepted and dropped. Any index past 3 reads zero and raises a one-cycle error pulse. Read data and the error pulse are registered and appear in the cycle after the request.

Top module: `slot_irq_regs`

## Requirements
- R1: While reset is held and after it is released, the card status bit (bit 3 of index 2), `card_irq`, `rd_data` and `acc_err` are all 0.
- R2: A clock edge that samples `card_in` high sets bit 3 of index 2, and `card_irq` is high from that edge on.
- R3: Once set, bit 3 and `card_irq` stay high when `card_in` returns low, until a clearing write.
- R4: A write to index 2 whose data has bit 3 set clears bit 3 and drops `card_irq` at that edge; a write to index 2 with bit 3 of the data clear changes nothing.
- R5: Bit 0 of index 2 reads 1 when `wp_in` is high and 0 when it is low, following the level at the read edge with no latching; bits other than 0 and 3 of index 2 read 0.
- R6: A read of index 0 returns the parameter `ID_VALUE`.
- R7: Reads of index 1 and index 3 return 0, and writes to them change neither the status word nor `card_irq`.
- R8: An access of either kind to an index above 3 returns 0 on a read and drives `acc_err` high for exactly the cycle after that access; in-range accesses leave `acc_err` low.
- R9: When `card_in` is high at the same edge as a clearing write to index 2, the set wins and bit 3 stays 1.
- R10: `rd_data` takes a new value only in the cycle after a read request and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_index | input | IDX_W | Word index of the access |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, registered |
| acc_err | output | 1 | One-cycle pulse for an out-of-range access |
| card_in | input | 1 | Card-insertion detector level |
| wp_in | input | 1 | Write-protect switch level |
| card_irq | output | 1 | Interrupt, follows the sticky card status bit |

## Verification
The card detector setting the sticky bit and software clearing it are the two functions that can land on one clock edge. The bench provokes this by raising `card_in` in the same cycle as a write of bit 3 to index 2. It then judges the outcome by reading index 2 and watching `card_irq`: both must still show the card present. A second clearing write with `card_in` low must then drop both.

// File: rtl/slot_regs_pkg.sv
package slot_regs_pkg;
  localparam int IDX_ID     = 0;
  localparam int IDX_FLASH  = 1;
  localparam int IDX_STATUS = 2;
  localparam int IDX_DECODE = 3;
  localparam int NUM_REGS   = 4;

  localparam int WP_BIT     = 0;
  localparam int CARD_BIT   = 3;

  typedef enum logic [1:0] {
    SEL_ID     = 2'd0,
    SEL_FLASH  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_DECODE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/slot_rst_sync.sv
module slot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ni = chain_q[STAGES-1];
endmodule

// File: rtl/slot_card_latch.sv
module slot_card_latch (
  input  logic clk,
  input  logic rst_ni,
  input  logic card_in,
  input  logic clr_req,
  output logic card_bit
);
  logic card_q;
  logic card_d;
  logic card_en;

  always_comb begin
    card_en = card_in | clr_req;
    card_d  = card_q;
    if (card_en) begin
      // detector level has priority over the acknowledge
      card_d = card_in ? 1'b1 : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      card_q <= 1'b0;
    else if (card_en) card_q <= card_d;
  end

  assign card_bit = card_q;

  // R2
  card_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    card_in |=> card_bit);
  // R3
  card_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (card_bit && !clr_req) |=> card_bit);
  // R4
  card_clr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_req && !card_in) |=> !card_bit);
endmodule

// File: rtl/slot_reg_decode.sv
module slot_reg_decode
  import slot_regs_pkg::*;
#(
  parameter int                IDX_W    = 4,
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0C1D_5A01
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [IDX_W-1:0]  acc_index,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wp_in,
  input  logic              card_bit,
  output logic              clr_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              acc_err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic              in_range;
  reg_sel_e          sel;
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_q;
  logic              rd_en;
  logic              err_d;
  logic              err_q;

  always_comb begin
    in_range = (acc_index <= LAST_IDX);
    sel      = reg_sel_e'(acc_index[1:0]);
  end

  always_comb begin
    status_word           = '0;
    status_word[WP_BIT]   = wp_in;
    status_word[CARD_BIT] = card_bit;
  end

  always_comb begin
    clr_req = acc_valid && acc_write && in_range &&
              (sel == SEL_STATUS) && wr_data[CARD_BIT];
  end

  always_comb begin
    rd_en = acc_valid && !acc_write;
    rd_d  = '0;
    if (in_range) begin
      case (sel)
        SEL_ID:     rd_d = ID_VALUE;
        SEL_STATUS: rd_d = status_word;
        default:    rd_d = '0;
      endcase
    end
    err_d = acc_valid && !in_range;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
      if (rd_en) rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;
  assign acc_err = err_q;

  // R8
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc_valid && (acc_index > LAST_IDX)) |=> acc_err);
  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !acc_valid |=> !acc_err);
  // R6
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc_valid && !acc_write && (acc_index == '0)) |=> (rd_data == ID_VALUE));
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(acc_valid && !acc_write) |=> $stable(rd_data));
endmodule

// File: rtl/slot_irq_regs.sv
module slot_irq_regs
  import slot_regs_pkg::*;
#(
  parameter int                IDX_W    = 4,
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0C1D_5A01,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [IDX_W-1:0]  acc_index,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              acc_err,
  input  logic              card_in,
  input  logic              wp_in,
  output logic              card_irq
);
  logic rst_ni;
  logic card_bit;
  logic clr_req;

  slot_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  slot_card_latch u_latch (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .card_in  (card_in),
    .clr_req  (clr_req),
    .card_bit (card_bit)
  );

  slot_reg_decode #(
    .IDX_W    (IDX_W),
    .DATA_W   (DATA_W),
    .ID_VALUE (ID_VALUE)
  ) u_dec (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_index (acc_index),
    .wr_data   (wr_data),
    .wp_in     (wp_in),
    .card_bit  (card_bit),
    .clr_req   (clr_req),
    .rd_data   (rd_data),
    .acc_err   (acc_err)
  );

  assign card_irq = card_bit;

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_ni |=> (!card_irq || card_in) && !acc_err);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (card_in && clr_req) |=> card_irq);
endmodule

// File: tb/slot_irq_regs_test.sv
module slot_irq_regs_test;
  localparam int IDX_W  = 4;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] ID = 32'h0C1D_5A01;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              acc_valid;
  logic              acc_write;
  logic [IDX_W-1:0]  acc_index;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              acc_err;
  logic              card_in;
  logic              wp_in;
  logic              card_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  slot_irq_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ID_VALUE(ID)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_index(acc_index), .wr_data(wr_data), .rd_data(rd_data),
    .acc_err(acc_err), .card_in(card_in), .wp_in(wp_in), .card_irq(card_irq)
  );

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one access; returns at the negedge where registered results are visible
  task automatic access(bit wr, int idx, logic [DATA_W-1:0] d);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_write = wr;
    acc_index = IDX_W'(idx);
    wr_data   = d;
    @(negedge clk);
    acc_valid = 1'b0;
    acc_write = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {31'd0, card_irq}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 irq after reset", {31'd0, card_irq}, 32'd0);
    check("R1 err after reset", {31'd0, acc_err}, 32'd0);
    check("R1 rdata after reset", rd_data, 32'd0);
    access(1'b0, 2, '0);
    check("R1 status after reset", rd_data, 32'd0);
  endtask

  task automatic t_id;
    access(1'b0, 0, '0);
    check("R6 id read", rd_data, ID);
    check("R8 no err in range", {31'd0, acc_err}, 32'd0);
    repeat (2) @(negedge clk);
    check("R10 rdata holds", rd_data, ID);
  endtask

  task automatic t_sticky;
    @(negedge clk); card_in = 1'b1;
    @(negedge clk); card_in = 1'b0;
    check("R2 irq after set", {31'd0, card_irq}, 32'd1);
    repeat (3) @(negedge clk);
    check("R3 irq held", {31'd0, card_irq}, 32'd1);
    access(1'b0, 2, '0);
    check("R3 status held", rd_data, 32'h8);
  endtask

  task automatic t_clear;
    access(1'b1, 2, 32'hFFFF_FFF7);
    check("R4 no clear without bit3", {31'd0, card_irq}, 32'd1);
    access(1'b1, 2, 32'h0000_0008);
    check("R4 irq cleared", {31'd0, card_irq}, 32'd0);
    access(1'b0, 2, '0);
    check("R4 status cleared", rd_data, 32'h0);
  endtask

  task automatic t_wprot;
    wp_in = 1'b1;
    access(1'b0, 2, '0);
    check("R5 wp high", rd_data, 32'h1);
    wp_in = 1'b0;
    access(1'b0, 2, '0);
    check("R5 wp low not latched", rd_data, 32'h0);
  endtask

  task automatic t_placeholders;
    @(negedge clk); card_in = 1'b1;
    @(negedge clk); card_in = 1'b0;
    access(1'b1, 1, 32'hFFFF_FFFF);
    access(1'b1, 3, 32'hFFFF_FFFF);
    check("R7 writes keep irq", {31'd0, card_irq}, 32'd1);
    access(1'b0, 1, '0);
    check("R7 index1 reads 0", rd_data, 32'd0);
    access(1'b0, 3, '0);
    check("R7 index3 reads 0", rd_data, 32'd0);
    access(1'b0, 2, '0);
    check("R7 status intact", rd_data, 32'h8);
  endtask

  task automatic t_range;
    access(1'b0, 5, '0);
    check("R8 oor read data", rd_data, 32'd0);
    check("R8 oor read err", {31'd0, acc_err}, 32'd1);
    @(negedge clk);
    check("R8 err one cycle", {31'd0, acc_err}, 32'd0);
    access(1'b1, 9, 32'h8);
    check("R8 oor write err", {31'd0, acc_err}, 32'd1);
    check("R8 oor write no clear", {31'd0, card_irq}, 32'd1);
  endtask

  task automatic t_collision;
    @(negedge clk);
    card_in = 1'b1; acc_valid = 1'b1; acc_write = 1'b1;
    acc_index = 4'd2; wr_data = 32'h8;
    @(negedge clk);
    card_in = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
    check("R9 set wins irq", {31'd0, card_irq}, 32'd1);
    access(1'b0, 2, '0);
    check("R9 set wins status", rd_data, 32'h8);
    access(1'b1, 2, 32'h8);
    check("R9 later clear", {31'd0, card_irq}, 32'd0);
  endtask

  initial begin
    acc_valid = 1'b0; acc_write = 1'b0; acc_index = '0; wr_data = '0;
    card_in = 1'b0; wp_in = 1'b0; rst_n = 1'b0;
    t_reset();
    t_id();
    t_sticky();
    t_clear();
    t_wprot();
    t_placeholders();
    t_range();
    t_collision();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule